// File: doc/BRIEF.md
# Byte-oriented ADC SPI reader

This block is the host side of a link to a 12-bit successive-approximation converter with a serial output. It reads one conversion per request in the same way as a microcontroller SPI port that can only move whole bytes. It lowers chip select and waits a setup interval. It then issues a serial clock that idles low, for 16 periods in two groups of eight, and samples the converter's data line on each rising edge. The converter changes its output on falling edges, so rising-edge sampling sees a settled bit.

The 16 captured bits hold the following, in arrival order:
- two undefined bits;
- the converter's null bit;
- the twelve result bits, most significant first;
- a copy of bit 1, which appears because the converter starts its least-significant-first replay.

The block rebuilds the 12-bit code with fixed byte shifts. It raises chip select after a hold interval and presents the code with a one-cycle done pulse. An error flag on the same cycle reports a non-zero null bit. The divider and the chip-select intervals are parameters in system clocks. A static flag reports a configuration whose timing breaks the converter's limits. The most important of these limits is the 1.2 ms ceiling on the time from sampling to the last data bit.

Top module: `adc_byte_reader`

## Requirements
- R1: While reset is held and right after its release, cs_n is 1, sclk is 0, done is 0.
- R2: sclk is 0 whenever cs_n is 1. Each high phase and each low phase of sclk lasts at least DIV_HALF system clocks.
- R3: Each read gives exactly 16 rising sclk edges while cs_n is low. miso is sampled on each rising edge.
- R4: The first rising sclk edge comes at least CS_SETUP system clocks after cs_n falls.
- R5: The received bits are numbered k = 1..16 in order. The result is bits k=4..15 with k=4 as the most significant bit (first byte bits [4:0], second byte bits [7:1]). Bits k=1, 2 and 16 have no effect on the result.
- R6: cs_n rises exactly HOLD_CYC system clocks after the falling sclk edge that follows the 16th rising edge. done is 1 for exactly that one cycle, and result is valid while done is 1.
- R7: null_err is 1 with done when received bit k=3 is 1, and 0 when it is 0.
- R8: After a read, cs_n stays high for at least CS_IDLE system clocks. A start pulse is ignored in two cases: while a read is in progress, and before that interval has elapsed. An ignored pulse produces no later read.
- R9: cfg_err is 1 when the system clock period SYS_NS, together with the parameters, gives any of the following:
  - a clock half period under 312 ns;
  - a setup time under 100 ns;
  - a deassertion time under 625 ns;
  - 13 sclk periods longer than 1.2 ms.

  Otherwise cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read (one-cycle pulse) |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Rebuilt conversion code |
| null_err | output | 1 | Null bit was not zero (valid with done) |
| cfg_err | output | 1 | Static flag: parameters break converter timing |

## Verification
A wrong bit counter shows up within one read. The bench sees a rising-edge count on sclk other than 16, or cs_n rising at the wrong distance from the last falling edge. A slip in the capture or rebuild shifts the code by one position, or lets an undefined or duplicated bit leak into it. Codes with alternating bits, all-ones and all-zeros expose such a slip at the first done pulse. A wrong ready or busy state becomes visible as an extra chip-select frame, or as a gap that is too short, within a few hundred system clocks of the ignored start.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_HOLD  = 2'd3
  } rd_state_t;

  localparam int FRAME_BITS = 16;

  // raw[15] is the first bit received, raw[0] the last
  function automatic logic [11:0] rebuild(input logic [15:0] raw);
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] hi_fix;
    logic [7:0] lo_fix;
    hi = raw[15:8];
    lo = raw[7:0];
    lo_fix = {hi[0], lo[7:1]};   // drop the repeated bit, pull bit 7 down
    hi_fix = {1'b0, hi[7:1]};
    return {hi_fix[3:0], lo_fix};
  endfunction

  function automatic logic null_bit(input logic [15:0] raw);
    return raw[13];
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
  parameter int DIV_HALF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !sclk;
  assign fall_evt = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_rx.sv
`timescale 1ns/1ps
module adc_shift_rx #(
  parameter int NBITS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       sample,
  input  logic                       din,
  output logic [NBITS-1:0]           raw,
  output logic [$clog2(NBITS+1)-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw   <= '0;
      count <= '0;
    end else if (clear) begin
      raw   <= '0;
      count <= '0;
    end else if (sample) begin
      raw   <= {raw[NBITS-2:0], din};
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/adc_cfg_check.sv
`timescale 1ns/1ps
module adc_cfg_check #(
  parameter int DIV_HALF = 64,
  parameter int CS_SETUP = 20,
  parameter int CS_IDLE  = 125,
  parameter int SYS_NS   = 5
) (
  output logic cfg_err
);
  localparam longint HALF_NS  = longint'(DIV_HALF) * SYS_NS;
  localparam longint SETUP_NS = longint'(CS_SETUP) * SYS_NS;
  localparam longint IDLE_NS  = longint'(CS_IDLE) * SYS_NS;
  localparam longint CONV_NS  = 64'd13 * 2 * HALF_NS;
  localparam bit BAD_HALF  = HALF_NS < 312;
  localparam bit BAD_SETUP = SETUP_NS < 100;
  localparam bit BAD_IDLE  = IDLE_NS < 625;
  localparam bit BAD_CONV  = CONV_NS > 1200000;

  assign cfg_err = BAD_HALF | BAD_SETUP | BAD_IDLE | BAD_CONV;
endmodule

// File: rtl/adc_byte_reader.sv
`timescale 1ns/1ps
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF = 64,
  parameter int CS_SETUP = 20,
  parameter int CS_IDLE  = 125,
  parameter int HOLD_CYC = 4,
  parameter int SYS_NS   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        miso,
  output logic        sclk,
  output logic        cs_n,
  output logic        done,
  output logic [11:0] result,
  output logic        null_err,
  output logic        cfg_err
);
  localparam int TMAX = (CS_SETUP > HOLD_CYC) ? CS_SETUP : HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(CS_IDLE + 1);
  localparam int NW   = $clog2(FRAME_BITS + 1);

  rd_state_t        state;
  logic [TW-1:0]    tmr;
  logic [IW-1:0]    idle_cnt;
  logic             run;
  logic             rise_evt;
  logic             fall_evt;
  logic             busy;
  logic             ready;
  logic             frame_end;
  logic [15:0]      rx_raw;
  logic [NW-1:0]    rx_cnt;

  assign run       = (state == ST_XFER);
  assign busy      = (state != ST_IDLE);
  assign ready     = !busy && (idle_cnt == IW'(CS_IDLE));
  assign frame_end = run && fall_evt && (rx_cnt == NW'(FRAME_BITS));

  adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  adc_shift_rx #(.NBITS(FRAME_BITS)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state == ST_SETUP),
    .sample (rise_evt),
    .din    (miso),
    .raw    (rx_raw),
    .count  (rx_cnt)
  );

  adc_cfg_check #(
    .DIV_HALF (DIV_HALF),
    .CS_SETUP (CS_SETUP),
    .CS_IDLE  (CS_IDLE),
    .SYS_NS   (SYS_NS)
  ) u_cfg (
    .cfg_err (cfg_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      tmr      <= '0;
      idle_cnt <= '0;
      done     <= 1'b0;
      result   <= '0;
      null_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (idle_cnt != IW'(CS_IDLE)) idle_cnt <= idle_cnt + 1'b1;
          if (start && ready) begin
            cs_n  <= 1'b0;
            tmr   <= '0;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tmr == TW'(CS_SETUP - 1)) begin
            tmr   <= '0;
            state <= ST_XFER;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_XFER: begin
          if (frame_end) begin
            tmr   <= '0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tmr == TW'(HOLD_CYC - 1)) begin
            cs_n     <= 1'b1;
            done     <= 1'b1;
            result   <= rebuild(rx_raw);
            null_err <= null_bit(rx_raw);
            idle_cnt <= '0;
            state    <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_byte_reader_chk.sv
`timescale 1ns/1ps
module adc_byte_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic done,
  input logic rise_evt,
  input logic busy
);
  logic [4:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rise_cnt <= '0;
    else if (cs_n)     rise_cnt <= '0;
    else if (rise_evt) rise_cnt <= rise_cnt + 1'b1;
  end

  a_r2_sclk_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r3_rise_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !cs_n);

  a_r3_rise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> sclk);

  a_r3_no_extra_edges: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= 5'd16);

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  a_r8_frame_starts_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));
endmodule

bind adc_byte_reader adc_byte_reader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .done     (done),
  .rise_evt (rise_evt),
  .busy     (busy)
);

// File: tb/sim_adc_byte_reader.sv
`timescale 1ns/1ps
module sim_adc_byte_reader;
  localparam int DIV_HALF = 64;
  localparam int CS_SETUP = 20;
  localparam int CS_IDLE  = 125;
  localparam int HOLD_CYC = 4;
  localparam real TCLK    = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b1;
  logic sclk, cs_n, done, null_err, cfg_err;
  logic [11:0] result;
  logic slow_sclk, slow_cs, slow_done, slow_nerr, slow_cfg;
  logic fast_sclk, fast_cs, fast_done, fast_nerr, fast_cfg;
  logic [11:0] slow_res, fast_res;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  adc_byte_reader #(.DIV_HALF(DIV_HALF), .CS_SETUP(CS_SETUP), .CS_IDLE(CS_IDLE),
                    .HOLD_CYC(HOLD_CYC), .SYS_NS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .sclk(sclk),
    .cs_n(cs_n), .done(done), .result(result), .null_err(null_err), .cfg_err(cfg_err));

  // conversion window too long: 13 * 2 * 10000 * 5 ns = 1.3 ms
  adc_byte_reader #(.DIV_HALF(10000), .SYS_NS(5)) u_slow (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .miso(1'b0), .sclk(slow_sclk),
    .cs_n(slow_cs), .done(slow_done), .result(slow_res), .null_err(slow_nerr),
    .cfg_err(slow_cfg));

  // half period too short: 10 * 5 ns = 50 ns
  adc_byte_reader #(.DIV_HALF(10), .SYS_NS(5)) u_fast (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .miso(1'b0), .sclk(fast_sclk),
    .cs_n(fast_cs), .done(fast_done), .result(fast_res), .null_err(fast_nerr),
    .cfg_err(fast_cfg));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [11:0] dev_code = '0;
  logic        dev_null = 1'b0;
  logic        dev_junk = 1'b1;
  int          falls = 0;

  always @(negedge cs_n) begin
    falls = 0;
    miso  = dev_junk;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      falls++;
      if (falls == 1)       miso = dev_junk;
      else if (falls == 2)  miso = dev_null;
      else if (falls <= 14) miso = dev_code[14 - falls];
      else if (falls <= 25) miso = dev_code[falls - 14];
      else                  miso = 1'b0;
    end
  end

  // ---------------- timing monitors ----------------
  realtime t_csfall = 0, t_csrise = 0, t_rise = 0, t_fall = 0, t_last_fall = 0;
  int rises = 0;
  int cs_falls = 0;
  bit had_frame = 0;

  always @(negedge cs_n) begin
    if (rst_n) begin
      cs_falls++;
      if (had_frame)
        check(($realtime - t_csrise) >= CS_IDLE * TCLK, "R8", "cs_n high gap ns",
              longint'($realtime - t_csrise), longint'(CS_IDLE * TCLK));
      t_csfall = $realtime;
      rises = 0;
    end
  end

  always @(posedge sclk) begin
    rises++;
    if (rises == 1)
      check(($realtime - t_csfall) >= CS_SETUP * TCLK, "R4", "setup ns",
            longint'($realtime - t_csfall), longint'(CS_SETUP * TCLK));
    else
      check(($realtime - t_fall) >= DIV_HALF * TCLK, "R2", "sclk low ns",
            longint'($realtime - t_fall), longint'(DIV_HALF * TCLK));
    t_rise = $realtime;
  end

  always @(negedge sclk) begin
    check(($realtime - t_rise) >= DIV_HALF * TCLK, "R2", "sclk high ns",
          longint'($realtime - t_rise), longint'(DIV_HALF * TCLK));
    t_fall = $realtime;
    if (rises == 16) t_last_fall = $realtime;
  end

  always @(posedge cs_n) begin
    if (rst_n && $realtime > 0) begin
      check(rises == 16, "R3", "rising edges per frame", rises, 16);
      check((($realtime - t_last_fall) > (HOLD_CYC * TCLK - 0.1)) &&
            (($realtime - t_last_fall) < (HOLD_CYC * TCLK + 0.1)),
            "R6", "hold ns", longint'($realtime - t_last_fall), longint'(HOLD_CYC * TCLK));
      t_csrise = $realtime;
      had_frame = 1;
    end
  end

  // ---------------- scenarios ----------------
  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic do_read(input logic [11:0] code, input logic nbad, input logic junk);
    bit seen;
    dev_code = code;
    dev_null = nbad;
    dev_junk = junk;
    repeat (CS_IDLE + 10) @(negedge clk);
    pulse_start();
    wait_done(seen);
    check(seen, "R6", "done seen", seen, 1);
    check(result == code, "R5", "result", result, code);
    check(null_err == nbad, "R7", "null_err", null_err, nbad);
    @(negedge clk);
    check(done == 1'b0, "R6", "done width", done, 0);
  endtask

  task automatic t_reset();
    check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1", "idle after reset",
          {cs_n, sclk, done}, 3'b100);
  endtask

  task automatic t_cfg();
    check(cfg_err == 1'b0, "R9", "cfg_err default", cfg_err, 0);
    check(slow_cfg == 1'b1, "R9", "cfg_err slow clock", slow_cfg, 1);
    check(fast_cfg == 1'b1, "R9", "cfg_err fast clock", fast_cfg, 1);
  endtask

  task automatic t_start_ignored();
    bit seen;
    int n0;
    dev_code = 12'h3C6;
    dev_null = 1'b0;
    repeat (CS_IDLE + 10) @(negedge clk);
    n0 = cs_falls;
    pulse_start();
    repeat (400) @(negedge clk);
    pulse_start();                         // mid-frame request
    wait_done(seen);
    check(seen && result == 12'h3C6, "R8", "result with busy start", result, 12'h3C6);
    pulse_start();                         // inside deassertion window
    repeat (CS_IDLE + 60) @(negedge clk);
    check(cs_n == 1'b1, "R8", "cs_n stays high", cs_n, 1);
    check(cs_falls == n0 + 1, "R8", "frame count", cs_falls, n0 + 1);
  endtask

  initial begin
    #(150000 * TCLK);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    do_read(12'h000, 1'b0, 1'b1);   // undefined bits high, must not leak (R5)
    do_read(12'hFFF, 1'b0, 1'b0);
    do_read(12'hA5A, 1'b0, 1'b1);
    do_read(12'h5A5, 1'b0, 1'b0);
    do_read(12'hFFD, 1'b0, 1'b1);   // repeated bit is 0 among ones (R5)
    do_read(12'h002, 1'b0, 1'b0);   // repeated bit is 1 among zeros (R5)
    do_read(12'h801, 1'b1, 1'b1);   // null bit set (R7)
    do_read(12'h7FE, 1'b1, 1'b0);
    t_start_ignored();
    do_read(12'h123, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule